// File: doc/BRIEF.md
# Cumulative Thermal-Event Timer

This block measures how much time an active-low thermal throttle input has spent asserted, summing every assertion since the total was last read. A prescaled tick supplies the time base. Each tick that arrives while the input is asserted adds one count, and one count stands for 22.76 ms of assertion time. The total saturates rather than wrapping, and reading it returns the value and restarts the total from zero. Software can therefore sample it at a fixed interval and follow how the thermal stress grows over time.

The total is compared against a programmable limit. When the total goes past the limit, a sticky alert request is raised unless the alert mask is set. A limit of zero raises the alert on the very first assertion. A boost option forces fans to full duty while the input is asserted, but only the fans that were already running when the assertion began.

The input passes through a two-flop synchronizer before it is used. Counting and boost happen only when the timer is enabled and the shared pin is set to its thermal-timer function.

Top module: `therm_accum_timer`

## Requirements
- R1: Counting, alerting and boost are active only when CTRL (address 0) bit 0 is 1 and CTRL bits 5:4 equal 2'b01. CTRL resets to 0x00, so all of these functions start off. With only one of the two conditions met, the total stays 0.
- R2: Each tick that arrives while the synchronized input is low and the block is active adds 1 to the total. Ticks that arrive while the input is high are not counted, so separate assertions add together.
- R3: A read of TIMER (address 2) returns the total on reg_rdata one cycle after the read strobe and clears the total to 0. A read of LIMIT (address 1) returns the limit, which resets to 0xFF.
- R4: With LIMIT = 0x00 and the mask clear, the alert rises on the first assertion of the input, before any tick arrives.
- R5: With a nonzero limit, the alert rises once the total is greater than the limit. A total equal to the limit raises no alert.
- R6: When CTRL bit 2 (mask) is 1, going past the limit raises no alert.
- R7: The alert stays high until a read of STATUS (address 3), whose bit 0 returns the alert. The read clears the alert if the alert condition is no longer present.
- R8: The total saturates at its maximum value (0xFF) instead of wrapping.
- R9: When CTRL bit 1 (boost) is 1 and the block is active, fan_full_o[i] is high for as long as the input is asserted, for each fan i that was running when the assertion began.
- R10: A fan that was stopped when the assertion began is not forced to full duty, even if it starts during the assertion. With boost at 0, fan_full_o stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| therm_n_i | input | 1 | Asynchronous active-low thermal input |
| tick_i | input | 1 | Prescaled time tick, one-cycle pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid one cycle after the read strobe |
| fan_running_i | input | 4 | Per-fan running status |
| fan_full_o | output | 4 | Per-fan full-duty override |
| alert_o | output | 1 | Sticky alert request |

## Verification
The hardest case to reach from the ports is saturation. It requires more than 255 ticks during a single unread assertion with the mask set, so that no alert disturbs the later tests. A dedicated task holds the input low and issues 260 ticks before it reads the total. The stopped-fan case is also awkward: a fan must start running after the assertion has begun. The boost task therefore changes fan_running_i partway through an assertion that is already under way.

// File: rtl/therm_timer_pkg.sv
`timescale 1ns/1ps
// Shared register addresses and field positions for the thermal-event timer.
package therm_timer_pkg;
    localparam int DATA_W = 8;
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_LIMIT  = 2'd1;
    localparam logic [1:0] ADDR_TIMER  = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;
    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_BOOST_BIT = 1;
    localparam int CTRL_MASK_BIT  = 2;
    localparam int CTRL_FUNC_LSB  = 4;
    localparam logic [1:0] FUNC_THERM = 2'b01;
endpackage

// File: rtl/therm_sync.sv
`timescale 1ns/1ps
// Synchronizes the asynchronous active-low thermal input into an
// active-high "asserted" flag. Assumes STAGES >= 2.
module therm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic therm_n_i,
    output logic therm_act_o
);
    logic [STAGES-1:0] sync_q;

    // Shift the inverted input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], ~therm_n_i};
    end

    assign therm_act_o = sync_q[STAGES-1];
endmodule

// File: rtl/therm_accum.sv
`timescale 1ns/1ps
// Saturating accumulator of assertion ticks. Clear-on-read has priority
// over a plain hold; a tick in the clearing cycle is kept as 1.
module therm_accum #(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en_i,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic inc;
    assign inc = count_en_i && tick_i;

    // Count ticks while asserted, saturating; restart on read.
    always_ff @(posedge clk) begin
        if (!rst_n)                    acc_o <= '0;
        else if (clr_i)                acc_o <= inc ? ACC_W'(1) : '0;
        else if (inc && acc_o != ACC_MAX) acc_o <= acc_o + ACC_W'(1);
    end

    // R8
    acc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o == ACC_MAX && !clr_i) |=> acc_o == ACC_MAX);
    // R2
    acc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr_i && acc_o != ACC_MAX) |=> acc_o == $past(acc_o) + ACC_W'(1));
    // R1
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en_i && !clr_i) |=> $stable(acc_o));
endmodule

// File: rtl/therm_alert.sv
`timescale 1ns/1ps
// Sticky alert request: set when the total exceeds the limit (or on any
// assertion with a zero limit) unless masked; cleared by a status read.
module therm_alert #(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             therm_act_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] limit_i,
    input  logic             mask_i,
    input  logic             clr_i,
    output logic             alert_o
);
    logic exceed, set_alert;

    // Exceed condition: first assertion with zero limit, or total above limit.
    always_comb begin
        exceed    = active_i && (((limit_i == '0) && therm_act_i) || (acc_i > limit_i));
        set_alert = exceed && !mask_i;
    end

    // Hold the alert until a status read; a new set wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         alert_o <= 1'b0;
        else if (set_alert) alert_o <= 1'b1;
        else if (clr_i)     alert_o <= 1'b0;
    end

    // R6
    alert_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && !alert_o) |=> !alert_o);
    // R7
    alert_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_o && !clr_i) |=> alert_o);
    // R4
    alert_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && therm_act_i && limit_i == '0 && !mask_i) |=> alert_o);
endmodule

// File: rtl/fan_boost.sv
`timescale 1ns/1ps
// Per-fan full-duty override. A fan is eligible only if it was running
// at the onset of the assertion; eligibility holds for the whole event.
module fan_boost #(
    parameter int NUM_FANS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boost_en_i,
    input  logic                active_i,
    input  logic                therm_act_i,
    input  logic [NUM_FANS-1:0] fan_running_i,
    output logic [NUM_FANS-1:0] fan_full_o
);
    logic therm_prev_q, onset;

    // Remember the previous input level to find the start of an event.
    always_ff @(posedge clk) begin
        if (!rst_n) therm_prev_q <= 1'b0;
        else        therm_prev_q <= therm_act_i;
    end

    assign onset = therm_act_i && !therm_prev_q;

    for (genvar i = 0; i < NUM_FANS; i++) begin : g_fan
        logic elig_q, elig_now;

        // Capture whether this fan was running when the event began.
        always_ff @(posedge clk) begin
            if (!rst_n)     elig_q <= 1'b0;
            else if (onset) elig_q <= fan_running_i[i];
        end

        assign elig_now      = onset ? fan_running_i[i] : elig_q;
        assign fan_full_o[i] = boost_en_i && active_i && therm_act_i && elig_now;

        // R10
        boost_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fan_full_o[i]) |-> ($rose(therm_act_i) || $rose(boost_en_i) || $rose(active_i)));
    end
endmodule

// File: rtl/therm_regs.sv
`timescale 1ns/1ps
// Register port: control and limit storage, registered read data,
// clear strobes for the timer and status reads.
module therm_regs
    import therm_timer_pkg::*;
#(
    parameter int ACC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic              alert_i,
    output logic              active_o,
    output logic              boost_en_o,
    output logic              mask_o,
    output logic [ACC_W-1:0]  limit_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              timer_rd_o,
    output logic              status_rd_o
);
    logic [DATA_W-1:0] ctrl_q;

    // Store control and limit on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            limit_o <= '1;
        end else if (wr_i) begin
            if (addr_i == ADDR_CTRL)  ctrl_q  <= wdata_i;
            if (addr_i == ADDR_LIMIT) limit_o <= wdata_i[ACC_W-1:0];
        end
    end

    // Return the addressed register one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else if (rd_i) begin
            case (addr_i)
                ADDR_CTRL:  rdata_o <= ctrl_q;
                ADDR_LIMIT: rdata_o <= DATA_W'(limit_o);
                ADDR_TIMER: rdata_o <= DATA_W'(acc_i);
                default:    rdata_o <= DATA_W'(alert_i);
            endcase
        end
    end

    // Decode fields and read side-effect strobes.
    always_comb begin
        active_o    = ctrl_q[CTRL_EN_BIT] && (ctrl_q[CTRL_FUNC_LSB+:2] == FUNC_THERM);
        boost_en_o  = ctrl_q[CTRL_BOOST_BIT];
        mask_o      = ctrl_q[CTRL_MASK_BIT];
        timer_rd_o  = rd_i && (addr_i == ADDR_TIMER);
        status_rd_o = rd_i && (addr_i == ADDR_STATUS);
    end
endmodule

// File: rtl/therm_accum_timer.sv
`timescale 1ns/1ps
// Top: cumulative thermal-event timer with alert and fan boost.
// Assumes tick_i is a single-cycle pulse and ACC_W <= 8.
module therm_accum_timer #(
    parameter int ACC_W       = 8,
    parameter int NUM_FANS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                therm_n_i,
    input  logic                tick_i,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [7:0]          reg_wdata_i,
    output logic [7:0]          reg_rdata_o,
    input  logic [NUM_FANS-1:0] fan_running_i,
    output logic [NUM_FANS-1:0] fan_full_o,
    output logic                alert_o
);
    logic             therm_act, active, boost_en, mask, timer_rd, status_rd;
    logic [ACC_W-1:0] acc, limit;

    therm_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .therm_n_i(therm_n_i), .therm_act_o(therm_act));

    therm_regs #(.ACC_W(ACC_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
        .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .acc_i(acc), .alert_i(alert_o),
        .active_o(active), .boost_en_o(boost_en), .mask_o(mask), .limit_o(limit),
        .rdata_o(reg_rdata_o), .timer_rd_o(timer_rd), .status_rd_o(status_rd));

    therm_accum #(.ACC_W(ACC_W)) accum_i (
        .clk(clk), .rst_n(rst_n), .count_en_i(active && therm_act), .tick_i(tick_i),
        .clr_i(timer_rd), .acc_o(acc));

    therm_alert #(.ACC_W(ACC_W)) alert_i (
        .clk(clk), .rst_n(rst_n), .active_i(active), .therm_act_i(therm_act),
        .acc_i(acc), .limit_i(limit), .mask_i(mask), .clr_i(status_rd), .alert_o(alert_o));

    fan_boost #(.NUM_FANS(NUM_FANS)) boost_i (
        .clk(clk), .rst_n(rst_n), .boost_en_i(boost_en), .active_i(active),
        .therm_act_i(therm_act), .fan_running_i(fan_running_i), .fan_full_o(fan_full_o));

    // R3
    timer_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_rd && !tick_i) |=> acc == '0);
endmodule

// File: tb/therm_accum_timer_tb_top.sv
`timescale 1ns/1ps
module therm_accum_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       therm_n = 1'b1;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] fan_running = '0;
    logic [3:0] fan_full;
    logic       alert;
    int         n_checks = 0, n_fail = 0;
    logic [7:0] rd;

    always #2.5 clk = ~clk;

    therm_accum_timer dut_i (
        .clk(clk), .rst_n(rst_n), .therm_n_i(therm_n), .tick_i(tick),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .fan_running_i(fan_running), .fan_full_o(fan_full), .alert_o(alert));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_therm(input logic asserted);
        @(negedge clk); therm_n = ~asserted;
        repeat (4) @(negedge clk);
    endtask

    // Return to a quiet state: input released, timer and alert cleared.
    task automatic cleanup();
        set_therm(1'b0);
        rdreg(2'd2, rd);
        rdreg(2'd3, rd);
    endtask

    task automatic t_reset();
        check("R1 ctrl reset", reg_rdata, 0);
        check("R7 alert reset", alert, 0);
        check("R10 fan_full reset", fan_full, 0);
        rdreg(2'd0, rd); check("R1 ctrl reads 0", rd, 0);
        rdreg(2'd1, rd); check("R3 limit reset", rd, 8'hFF);
        rdreg(2'd2, rd); check("R3 timer reset", rd, 0);
    endtask

    task automatic t_gating();
        wr(2'd0, 8'h01);              // enable only
        set_therm(1'b1); ticks(5); cleanup();
        wr(2'd0, 8'h10);              // pin function only
        set_therm(1'b1); ticks(5); set_therm(1'b0);
        rdreg(2'd2, rd); check("R1 not counting without both", rd, 0);
        wr(2'd0, 8'h01);
        set_therm(1'b1); ticks(5); set_therm(1'b0);
        rdreg(2'd2, rd); check("R1 enable-only no count", rd, 0);
    endtask

    task automatic t_accumulate();
        wr(2'd0, 8'h11);
        set_therm(1'b1); ticks(3); set_therm(1'b0);
        ticks(2);
        set_therm(1'b1); ticks(4); set_therm(1'b0);
        rdreg(2'd2, rd); check("R2 total across events", rd, 7);
        rdreg(2'd2, rd); check("R3 read clears timer", rd, 0);
        check("R10 boost off no override", fan_full, 0);
    endtask

    task automatic t_limit_zero();
        wr(2'd1, 8'h00);
        set_therm(1'b1);
        check("R4 zero limit alerts on first assertion", alert, 1);
        set_therm(1'b0);
        repeat (3) @(negedge clk);
        check("R7 alert sticky", alert, 1);
        rdreg(2'd3, rd); check("R7 status bit0", rd, 1);
        @(negedge clk);
        check("R7 alert cleared by status read", alert, 0);
    endtask

    task automatic t_limit_three();
        wr(2'd1, 8'd3);
        set_therm(1'b1); ticks(3);
        repeat (2) @(negedge clk);
        check("R5 equal to limit no alert", alert, 0);
        ticks(1); repeat (2) @(negedge clk);
        check("R5 above limit alerts", alert, 1);
        cleanup();
        check("R7 cleared after cleanup", alert, 0);
    endtask

    task automatic t_mask();
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h15);
        set_therm(1'b1); ticks(2);
        check("R6 masked no alert", alert, 0);
        cleanup();
    endtask

    task automatic t_saturate();
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h15);
        set_therm(1'b1); ticks(260); set_therm(1'b0);
        rdreg(2'd2, rd); check("R8 saturates", rd, 255);
        check("R8 no alert at saturation", alert, 0);
        cleanup();
    endtask

    task automatic t_boost();
        wr(2'd0, 8'h17);
        fan_running = 4'b0101;
        set_therm(1'b1);
        check("R9 running fans forced", fan_full, 4'b0101);
        @(negedge clk); fan_running = 4'b1111;
        repeat (3) @(negedge clk);
        check("R10 late-started fans not forced", fan_full, 4'b0101);
        set_therm(1'b0);
        check("R9 override ends with input", fan_full, 0);
        wr(2'd0, 8'h15);
        set_therm(1'b1);
        check("R10 boost bit clear", fan_full, 0);
        cleanup();
        fan_running = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gating();
        t_accumulate();
        t_limit_zero();
        t_limit_three();
        t_mask();
        t_saturate();
        t_boost();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule